// File: doc/BRIEF.md
# Video Processor Host Port Interface

This block is the host-side bus front end of a tile-based video display processor. The host issues single 16-bit word reads and writes at a small set of word offsets. Writes to the control port either load one internal register in a single word, or set up a 16-bit memory address and a 6-bit access code across two consecutive words. A two-state command machine tracks whether the next control write is the second half of an address setup.

Data-port accesses use the stored address and access code. They drive a strobe, a memory select and a word index toward video RAM, color RAM or vertical-scroll RAM. After each access the address advances by a programmable step. A control-port read returns a status word assembled from flag inputs. A separate offset returns a packed vertical/horizontal counter word.

The command machine has two states. `ST_FIRST` is idle, waiting for a register write or the first address word. `ST_SECOND` means a first address word was taken and the second word is pending. The transitions are:
- `T_REGWR`: `ST_FIRST` to `ST_FIRST`, on a control write whose top bits are 10.
- `T_ADDR1`: `ST_FIRST` to `ST_SECOND`, on any other control write.
- `T_ADDR2`: `ST_SECOND` to `ST_FIRST`, on any control write.
- `T_ABORT`: `ST_SECOND` to `ST_FIRST`, on a data-port access or a control-port read.

Top module: `vdp_host_port`

## Requirements
- R1: In `ST_FIRST`, a control write with bits 15:14 = 10 pulses `reg_we` in that same cycle. The strobe carries `reg_num` = bits 12:8 and `reg_val` = bits 7:0. A write to register 15 sets the address step.
- R2: In `ST_FIRST`, any other control write loads address bits 13:0 from data bits 13:0 and code bits 1:0 from data bits 15:14, then enters `ST_SECOND`. Address bits 15:14 and code bits 5:2 keep their values.
- R3: In `ST_SECOND`, every control write is taken as the second word, even when its top bits are 10. It loads code bits 5:2 from data bits 7:4 and address bits 15:14 from data bits 1:0. It raises no `reg_we` and returns to `ST_FIRST`.
- R4: In `ST_SECOND`, a data-port access or a control-port read returns the machine to `ST_FIRST`, so the next control write with top bits 10 is a register write.
- R5: Code bits 3:0 choose the operation. 0001 is video RAM write and 0011 is color RAM write. 0101 is vertical-scroll RAM write and 0000 is video RAM read. 1000 is color RAM read and 0100 is vertical-scroll RAM read. `mem_sel` is 0 for video RAM, 1 for color RAM, 2 for vertical-scroll RAM and 3 for none. Code bits 5:4 are only stored and shown on `cur_code`.
- R6: `mem_index` is address bits 15:1 for video RAM, and address bits 6:1 for color and vertical-scroll RAM. A vertical-scroll index of 40 or more gives no strobe, and such a read returns 0.
- R7: Every data-port access, ignored or not, advances the address by the step after the access. The step is 2 after reset and the address wraps at 16 bits.
- R8: A data write under a read code, or a data read under a write code, raises no memory strobe. Such a read returns 0. `mem_we` and `mem_re` are never both high.
- R9: A control-port read returns `stat_flags` in bits 9:0 and zero in bits 15:10. The flag order from bit 9 down to bit 0 is: FIFO empty, FIFO full, vertical interrupt, sprite overflow, sprite collision, odd frame, vertical blank, horizontal blank, DMA busy, PAL.
- R10: A read at `bus_sel` 4 or 5 returns `{vcount[7:0], hcount}` when `interlace` is 0, and `{vcount[7:1], vcount[8], hcount}` when it is 1. `bus_sel` 6 and 7 read as 0 and are ignored on write.
- R11: `bus_sel` (byte offset bits 3:1) 0 and 1 both select the data port, and 2 and 3 both select the control port.
- R12: Reset clears the address and the code to 0, puts the machine in `ST_FIRST` and sets the step to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Host access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Word offset (byte offset bits 3:1) |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data (combinational) |
| stat_flags | input | 10 | Status flag inputs |
| vcount | input | 9 | Vertical line counter |
| hcount | input | 8 | Horizontal counter |
| interlace | input | 1 | Interlace mode flag |
| reg_we | output | 1 | Internal register write strobe |
| reg_num | output | 5 | Register number |
| reg_val | output | 8 | Register value |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_sel | output | 2 | Target memory |
| mem_index | output | 15 | Word index into target memory |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data (combinational) |
| cur_addr | output | 16 | Current access address |
| cur_code | output | 6 | Current access code |

## Verification
The hardest case to reach is an address setup that is abandoned halfway. If the pending state does not clear, a later register write is taken as a second address word. The stimulus sends a lone first word and then a data read, or a control read. It then sends a register-style control word, and checks both that `reg_we` pulses and that the aborted half-setup left a mixed access code that makes the interrupting read return zero. The address wrap and the vertical-scroll index limit are reached by building the address through both setup words.

// File: rtl/vdp_hp_pkg.sv
package vdp_hp_pkg;

    typedef enum logic [1:0] {
        MEM_VRAM  = 2'd0,
        MEM_CRAM  = 2'd1,
        MEM_VSRAM = 2'd2,
        MEM_NONE  = 2'd3
    } mem_t;

    typedef enum logic [1:0] {
        PORT_DATA = 2'd0,
        PORT_CTRL = 2'd1,
        PORT_HV   = 2'd2,
        PORT_NONE = 2'd3
    } port_t;

    typedef enum logic {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } cmd_state_t;

    // word offset -> port; offsets pair up as mirrors
    function automatic port_t decode_port(input logic [2:0] sel);
        port_t p;
        unique case (sel[2:1])
            2'b00:   p = PORT_DATA;
            2'b01:   p = PORT_CTRL;
            2'b10:   p = PORT_HV;
            default: p = PORT_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/vdp_hp_cmd_fsm.sv
module vdp_hp_cmd_fsm
    import vdp_hp_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int RNW       = 5,
    parameter int INC_REG   = 15,
    parameter int INC_RESET = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_wr,
    input  logic           ctl_rd,
    input  logic           data_acc,
    input  logic [DW-1:0]  wdata,
    output logic           reg_we,
    output logic [RNW-1:0] reg_num,
    output logic [7:0]     reg_val,
    output logic [AW-1:0]  addr,
    output logic [5:0]     code,
    output logic           pend,
    output logic [AW-1:0]  incr
);
    localparam int LOW_AW = AW - 2;

    cmd_state_t state_q, state_d;
    logic       ld_first, ld_second;
    logic       is_reg_word;
    logic [7:0] incr_q;

    assign is_reg_word = (wdata[15:14] == 2'b10);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FIRST;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIRST: begin
                if (ctl_wr && !is_reg_word) state_d = ST_SECOND;  // T_ADDR1
            end
            ST_SECOND: begin
                if (ctl_wr)                    state_d = ST_FIRST; // T_ADDR2
                else if (ctl_rd || data_acc)   state_d = ST_FIRST; // T_ABORT
            end
            default: state_d = ST_FIRST;
        endcase
    end

    // state outputs
    always_comb begin
        reg_we    = 1'b0;
        ld_first  = 1'b0;
        ld_second = 1'b0;
        unique case (state_q)
            ST_FIRST: begin
                reg_we   = ctl_wr && is_reg_word;                  // T_REGWR
                ld_first = ctl_wr && !is_reg_word;
            end
            ST_SECOND: begin
                ld_second = ctl_wr;
            end
            default: ;
        endcase
    end

    assign reg_num = wdata[8+RNW-1:8];
    assign reg_val = wdata[7:0];
    assign pend    = (state_q == ST_SECOND);
    assign incr    = {{(AW-8){1'b0}}, incr_q};

    // address / code / step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            code   <= '0;
            incr_q <= 8'(INC_RESET);
        end else begin
            if (ld_first) begin
                addr[LOW_AW-1:0] <= wdata[LOW_AW-1:0];
                code[1:0]        <= wdata[15:14];
            end else if (ld_second) begin
                addr[AW-1:LOW_AW] <= wdata[1:0];
                code[5:2]         <= wdata[7:4];
            end else if (data_acc) begin
                addr <= addr + incr;
            end
            if (reg_we && (reg_num == RNW'(INC_REG))) incr_q <= reg_val;
        end
    end

endmodule

// File: rtl/vdp_hp_access_dec.sv
module vdp_hp_access_dec
    import vdp_hp_pkg::*;
#(
    parameter int AW          = 16,
    parameter int CRAM_WORDS  = 64,
    parameter int VSRAM_WORDS = 40
) (
    input  logic [3:0]    code_lo,
    input  logic [AW-1:1] word_addr,
    input  logic          data_wr,
    input  logic          data_rd,
    output logic          mem_we,
    output logic          mem_re,
    output logic [1:0]    mem_sel,
    output logic [AW-2:0] mem_index,
    output logic          rd_ok
);
    localparam int IDXW = $clog2(CRAM_WORDS);

    mem_t           target;
    logic           is_write, is_read, in_range;
    logic [IDXW-1:0] small_idx;

    always_comb begin
        target   = MEM_NONE;
        is_write = 1'b0;
        is_read  = 1'b0;
        unique case (code_lo)
            4'b0001: begin target = MEM_VRAM;  is_write = 1'b1; end
            4'b0011: begin target = MEM_CRAM;  is_write = 1'b1; end
            4'b0101: begin target = MEM_VSRAM; is_write = 1'b1; end
            4'b0000: begin target = MEM_VRAM;  is_read  = 1'b1; end
            4'b1000: begin target = MEM_CRAM;  is_read  = 1'b1; end
            4'b0100: begin target = MEM_VSRAM; is_read  = 1'b1; end
            default: ;
        endcase
    end

    assign small_idx = word_addr[IDXW:1];

    always_comb begin
        unique case (target)
            MEM_VSRAM: in_range = ({1'b0, small_idx} < (IDXW+1)'(VSRAM_WORDS));
            MEM_CRAM:  in_range = ({1'b0, small_idx} < (IDXW+1)'(CRAM_WORDS));
            default:   in_range = 1'b1;
        endcase
    end

    always_comb begin
        if (target == MEM_VRAM) mem_index = word_addr[AW-1:1];
        else                    mem_index = {{(AW-1-IDXW){1'b0}}, small_idx};
    end

    assign mem_sel = target;
    assign rd_ok   = is_read && in_range;
    assign mem_re  = data_rd && rd_ok;
    assign mem_we  = data_wr && is_write && in_range;

endmodule

// File: rtl/vdp_hp_read_mux.sv
module vdp_hp_read_mux
    import vdp_hp_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 10
) (
    input  port_t         port,
    input  logic          rd,
    input  logic          rd_ok,
    input  logic [DW-1:0] mem_rdata,
    input  logic [SW-1:0] stat_flags,
    input  logic [8:0]    vcount,
    input  logic [7:0]    hcount,
    input  logic          interlace,
    output logic [DW-1:0] rdata
);
    logic [7:0] vbyte;

    assign vbyte = interlace ? {vcount[7:1], vcount[8]} : vcount[7:0];

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (port)
                PORT_DATA: rdata = rd_ok ? mem_rdata : '0;
                PORT_CTRL: rdata = {{(DW-SW){1'b0}}, stat_flags};
                PORT_HV:   rdata = DW'({vbyte, hcount});
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vdp_hp_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int SW          = 10,
    parameter int RNW         = 5,
    parameter int INC_REG     = 15,
    parameter int INC_RESET   = 2,
    parameter int CRAM_WORDS  = 64,
    parameter int VSRAM_WORDS = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_req,
    input  logic           bus_we,
    input  logic [2:0]     bus_sel,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [SW-1:0]  stat_flags,
    input  logic [8:0]     vcount,
    input  logic [7:0]     hcount,
    input  logic           interlace,
    output logic           reg_we,
    output logic [RNW-1:0] reg_num,
    output logic [7:0]     reg_val,
    output logic           mem_we,
    output logic           mem_re,
    output logic [1:0]     mem_sel,
    output logic [AW-2:0]  mem_index,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  cur_addr,
    output logic [5:0]     cur_code
);
    port_t         port;
    logic          ctl_wr, ctl_rd, data_wr, data_rd, data_acc;
    logic          pend, rd_ok;
    logic [AW-1:0] incr;

    assign port     = decode_port(bus_sel);
    assign ctl_wr   = bus_req &&  bus_we && (port == PORT_CTRL);
    assign ctl_rd   = bus_req && !bus_we && (port == PORT_CTRL);
    assign data_wr  = bus_req &&  bus_we && (port == PORT_DATA);
    assign data_rd  = bus_req && !bus_we && (port == PORT_DATA);
    assign data_acc = data_wr || data_rd;

    assign mem_wdata = bus_wdata;

    vdp_hp_cmd_fsm #(
        .AW(AW), .DW(DW), .RNW(RNW), .INC_REG(INC_REG), .INC_RESET(INC_RESET)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_rd   (ctl_rd),
        .data_acc (data_acc),
        .wdata    (bus_wdata),
        .reg_we   (reg_we),
        .reg_num  (reg_num),
        .reg_val  (reg_val),
        .addr     (cur_addr),
        .code     (cur_code),
        .pend     (pend),
        .incr     (incr)
    );

    vdp_hp_access_dec #(
        .AW(AW), .CRAM_WORDS(CRAM_WORDS), .VSRAM_WORDS(VSRAM_WORDS)
    ) u_dec (
        .code_lo   (cur_code[3:0]),
        .word_addr (cur_addr[AW-1:1]),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_sel   (mem_sel),
        .mem_index (mem_index),
        .rd_ok     (rd_ok)
    );

    vdp_hp_read_mux #(
        .DW(DW), .SW(SW)
    ) u_rmux (
        .port       (port),
        .rd         (bus_req && !bus_we),
        .rd_ok      (rd_ok),
        .mem_rdata  (mem_rdata),
        .stat_flags (stat_flags),
        .vcount     (vcount),
        .hcount     (hcount),
        .interlace  (interlace),
        .rdata      (bus_rdata)
    );

endmodule

// File: rtl/vdp_host_port_chk.sv
module vdp_host_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic [2:0]  bus_sel,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        reg_we,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] cur_addr,
    input logic        pend,
    input logic [15:0] incr
);
    logic is_ctl, is_data;
    assign is_ctl  = bus_req && (bus_sel[2:1] == 2'b01);
    assign is_data = bus_req && (bus_sel[2:1] == 2'b00);

    AST_REG_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (is_ctl && bus_we && !pend && bus_wdata[15:14] == 2'b10)); // R1

    AST_FIRST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && bus_we && !pend && bus_wdata[15:14] != 2'b10)
        |=> (pend && cur_addr[13:0] == $past(bus_wdata[13:0]))); // R2

    AST_SECOND_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && bus_we && pend)
        |=> (!pend && cur_addr[15:14] == $past(bus_wdata[1:0]))); // R3

    AST_PENDING_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && (is_data || (is_ctl && !bus_we))) |=> !pend); // R4

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        is_data |=> (cur_addr == $past(cur_addr) + $past(incr))); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re})); // R8

    AST_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (is_data && bus_we)); // R8

    AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && !bus_we) |-> (bus_rdata[15:10] == 6'd0)); // R9

endmodule

bind vdp_host_port vdp_host_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .reg_we    (reg_we),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .cur_addr  (cur_addr),
    .pend      (pend),
    .incr      (incr)
);

// File: tb/sim_vdp_host_port.sv
module sim_vdp_host_port;
    localparam time CLK_PERIOD = 10ns;

    localparam int S_RDATA  = 0;
    localparam int S_REGWE  = 1;
    localparam int S_REGNUM = 2;
    localparam int S_REGVAL = 3;
    localparam int S_MEMWE  = 4;
    localparam int S_MEMRE  = 5;
    localparam int S_MEMSEL = 6;
    localparam int S_MEMIDX = 7;
    localparam int S_MEMWD  = 8;
    localparam int S_ADDR   = 9;
    localparam int S_CODE   = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we;
    logic [2:0]  bus_sel;
    logic [15:0] bus_wdata, bus_rdata;
    logic [9:0]  stat_flags;
    logic [8:0]  vcount;
    logic [7:0]  hcount;
    logic        interlace;
    logic        reg_we;
    logic [4:0]  reg_num;
    logic [7:0]  reg_val;
    logic        mem_we, mem_re;
    logic [1:0]  mem_sel;
    logic [14:0] mem_index;
    logic [15:0] mem_wdata, mem_rdata;
    logic [15:0] cur_addr;
    logic [5:0]  cur_code;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    n_vec  = 0;
    int    n_miss = 0;
    bit    done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: data depends on target and index
    function automatic logic [15:0] mem_model(input logic [1:0] s, input logic [14:0] i);
        return {s, i[13:0]} ^ 16'hA5A5;
    endfunction
    assign mem_rdata = mem_model(mem_sel, mem_index);

    vdp_host_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_flags(stat_flags), .vcount(vcount), .hcount(hcount),
        .interlace(interlace), .reg_we(reg_we), .reg_num(reg_num),
        .reg_val(reg_val), .mem_we(mem_we), .mem_re(mem_re),
        .mem_sel(mem_sel), .mem_index(mem_index), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cur_addr(cur_addr), .cur_code(cur_code)
    );

    function automatic logic [31:0] sample(input int s);
        case (s)
            S_RDATA:  return 32'(bus_rdata);
            S_REGWE:  return 32'(reg_we);
            S_REGNUM: return 32'(reg_num);
            S_REGVAL: return 32'(reg_val);
            S_MEMWE:  return 32'(mem_we);
            S_MEMRE:  return 32'(mem_re);
            S_MEMSEL: return 32'(mem_sel);
            S_MEMIDX: return 32'(mem_index);
            S_MEMWD:  return 32'(mem_wdata);
            S_ADDR:   return 32'(cur_addr);
            default:  return 32'(cur_code);
        endcase
    endfunction

    // monitor: compare all queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = sb.pop_front();
                got = sample(it.sel);
                n_vec++;
                if (got !== it.exp) begin
                    n_miss++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input int s, input logic [31:0] v, input string r);
        item_t it;
        it.sel = s; it.exp = v; it.req = r;
        sb.push_back(it);
    endtask

    task automatic drive(input logic we, input logic [2:0] sel, input logic [15:0] wd);
        bus_req = 1'b1; bus_we = we; bus_sel = sel; bus_wdata = wd;
    endtask

    task automatic step();
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic ctl(input logic [15:0] w);
        drive(1'b1, 3'd2, w); step();
    endtask

    task automatic setup(input logic [15:0] w1, input logic [15:0] w2);
        ctl(w1); ctl(w2);
    endtask

    task automatic check_addr(input logic [15:0] a, input string r);
        expect_v(S_ADDR, 32'(a), r); step();
    endtask

    initial begin
        rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_sel = 0; bus_wdata = 0;
        stat_flags = 0; vcount = 0; hcount = 0; interlace = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        expect_v(S_ADDR, 0, "R12"); expect_v(S_CODE, 0, "R12");
        expect_v(S_REGWE, 0, "R12"); expect_v(S_MEMWE, 0, "R12");
        step();

        // R1 register writes, step -> 4; R11 control mirror at offset 3
        drive(1'b1, 3'd2, 16'h8F04);
        expect_v(S_REGWE, 1, "R1"); expect_v(S_REGNUM, 15, "R1"); expect_v(S_REGVAL, 4, "R1");
        step();
        drive(1'b1, 3'd3, 16'h8105);
        expect_v(S_REGWE, 1, "R11"); expect_v(S_REGNUM, 1, "R11"); expect_v(S_REGVAL, 5, "R11");
        step();

        // R2 first word, R3 second word with top bits 10
        ctl(16'h4010);
        expect_v(S_CODE, 6'h01, "R2"); check_addr(16'h0010, "R2");
        drive(1'b1, 3'd2, 16'h8002);
        expect_v(S_REGWE, 0, "R3");
        step();
        expect_v(S_CODE, 6'h01, "R3"); check_addr(16'h8010, "R3");

        // R5/R6/R7 video RAM writes on both data mirrors (R11)
        drive(1'b1, 3'd0, 16'h1234);
        expect_v(S_MEMWE, 1, "R5"); expect_v(S_MEMRE, 0, "R5"); expect_v(S_MEMSEL, 0, "R5");
        expect_v(S_MEMIDX, 15'h4008, "R6"); expect_v(S_MEMWD, 16'h1234, "R5");
        step();
        check_addr(16'h8014, "R7");
        drive(1'b1, 3'd1, 16'h5678);
        expect_v(S_MEMWE, 1, "R11"); expect_v(S_MEMIDX, 15'h400A, "R11");
        step();
        check_addr(16'h8018, "R7");

        // R7 wrap with step 2
        ctl(16'h8F02);
        setup(16'h7FFE, 16'h0003);
        check_addr(16'hFFFE, "R7");
        drive(1'b1, 3'd0, 16'hBEEF);
        expect_v(S_MEMIDX, 15'h7FFF, "R6");
        step();
        check_addr(16'h0000, "R7");

        // R8 read under write code
        drive(1'b0, 3'd0, 16'h0);
        expect_v(S_RDATA, 0, "R8"); expect_v(S_MEMRE, 0, "R8");
        step();
        check_addr(16'h0002, "R7");

        // R5/R6 color RAM write, index from low bits
        setup(16'hC1C6, 16'h0000);
        expect_v(S_CODE, 6'h03, "R5"); step();
        drive(1'b1, 3'd0, 16'h0F0F);
        expect_v(S_MEMWE, 1, "R5"); expect_v(S_MEMSEL, 1, "R5"); expect_v(S_MEMIDX, 15'h23, "R6");
        step();

        // color RAM read, then write under read code (R8)
        setup(16'h0004, 16'h0020);
        expect_v(S_CODE, 6'h08, "R5"); step();
        drive(1'b0, 3'd0, 16'h0);
        expect_v(S_MEMRE, 1, "R5"); expect_v(S_MEMSEL, 1, "R5"); expect_v(S_MEMIDX, 2, "R6");
        expect_v(S_RDATA, 32'(mem_model(2'd1, 15'd2)), "R5");
        step();
        drive(1'b1, 3'd0, 16'hAAAA);
        expect_v(S_MEMWE, 0, "R8");
        step();
        check_addr(16'h0008, "R7");

        // vertical-scroll read at index 39, then 40 (R6)
        setup(16'h004E, 16'h0010);
        drive(1'b0, 3'd0, 16'h0);
        expect_v(S_MEMRE, 1, "R5"); expect_v(S_MEMSEL, 2, "R5"); expect_v(S_MEMIDX, 39, "R6");
        expect_v(S_RDATA, 32'(mem_model(2'd2, 15'd39)), "R5");
        step();
        drive(1'b0, 3'd0, 16'h0);
        expect_v(S_MEMRE, 0, "R6"); expect_v(S_RDATA, 0, "R6");
        step();

        // vertical-scroll write
        setup(16'h4002, 16'h0010);
        drive(1'b1, 3'd0, 16'h0101);
        expect_v(S_MEMWE, 1, "R5"); expect_v(S_MEMSEL, 2, "R5"); expect_v(S_MEMIDX, 1, "R6");
        step();

        // R4 abort by data read: code now mixes to a write code, read yields 0
        ctl(16'h4100);
        drive(1'b0, 3'd0, 16'h0);
        expect_v(S_RDATA, 0, "R4"); expect_v(S_MEMRE, 0, "R4");
        step();
        drive(1'b1, 3'd2, 16'h8F06);
        expect_v(S_REGWE, 1, "R4"); expect_v(S_REGVAL, 6, "R4");
        step();
        ctl(16'h8F02);

        // R4 abort by control read; R9 status word
        ctl(16'h4000);
        stat_flags = 10'b10_1011_0011;
        drive(1'b0, 3'd2, 16'h0);
        expect_v(S_RDATA, 16'h02B3, "R9");
        step();
        drive(1'b1, 3'd2, 16'h8105);
        expect_v(S_REGWE, 1, "R4"); expect_v(S_REGNUM, 1, "R4");
        step();
        stat_flags = 10'h3FF;
        drive(1'b0, 3'd3, 16'h0);
        expect_v(S_RDATA, 16'h03FF, "R9");
        step();

        // R10 counter word
        vcount = 9'h1A4; hcount = 8'h3C; interlace = 1'b0;
        drive(1'b0, 3'd4, 16'h0);
        expect_v(S_RDATA, 16'hA43C, "R10");
        step();
        interlace = 1'b1;
        drive(1'b0, 3'd5, 16'h0);
        expect_v(S_RDATA, 16'hA53C, "R10");
        step();
        vcount = 9'h0A5;
        drive(1'b0, 3'd4, 16'h0);
        expect_v(S_RDATA, 16'hA43C, "R10");
        step();
        drive(1'b0, 3'd6, 16'h0);
        expect_v(S_RDATA, 0, "R10");
        step();
        drive(1'b1, 3'd7, 16'h8F09);
        expect_v(S_REGWE, 0, "R10");
        step();

        // R5 code bits 5:4 stored but not decoded
        setup(16'h4000, 16'h00C0);
        expect_v(S_CODE, 6'h31, "R5"); step();
        drive(1'b1, 3'd0, 16'h7777);
        expect_v(S_MEMWE, 1, "R5"); expect_v(S_MEMSEL, 0, "R5"); expect_v(S_MEMIDX, 0, "R5");
        step();
        check_addr(16'h0002, "R7");

        // R12 reset mid-run restores step 2
        ctl(16'h8F08);
        setup(16'h4020, 16'h0000);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        expect_v(S_ADDR, 0, "R12"); expect_v(S_CODE, 0, "R12");
        step();
        drive(1'b0, 3'd0, 16'h0);
        expect_v(S_MEMRE, 1, "R12"); expect_v(S_MEMIDX, 0, "R12");
        step();
        check_addr(16'h0002, "R12");

        step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule